// File: doc/BRIEF.md
# Dual-Channel Temperature Alert Controller

This block watches the result of a temperature sensor's conversion engine through two independent alert channels. Each channel holds a signed high limit, a signed low limit, a mode bit and a polarity bit. It produces a high flag, a low flag and an alert pin. The block does nothing between conversions. When the conversion-done strobe arrives, each channel compares the fresh result against its own limits and moves its state machine.

A channel runs in one of two modes. In window mode, an out-of-range result latches a flag and raises the pin. A configuration read clears the pin and the flags. A per-channel global clear drops only the pin. In hysteresis mode, the channel goes hot when a result rises above the high limit. It cools only when a later result falls below the low limit, and clears have no effect on it. The polarity bit sets the pin's active level. With its limits pushed to the extremes, a channel never trips, and its pin becomes a plain output set by the polarity bit.

Each channel's state machine has four named states:
- `CH_A_QUIET`: window mode with the pin inactive. The flags may still be set.
- `CH_A_RAISED`: window mode with the pin active.
- `CH_T_BELOW`: hysteresis mode, cool.
- `CH_T_ABOVE`: hysteresis mode, hot.

The transitions are:
- An out-of-window conversion moves QUIET to RAISED.
- A configuration read or a global clear moves RAISED to QUIET, unless a new event arrives in the same cycle.
- A conversion above the high limit moves BELOW to ABOVE.
- A conversion below the low limit moves ABOVE to BELOW.
- A write that flips the mode bit sends the channel to QUIET or BELOW, matching the new mode.

Top module: `dual_temp_alert`

## Requirements
- R1: The two channels are fully independent. Each has its own high and low limit registers. These reset to `HI_RST` and `LO_RST` and are loaded from `lim_wdata` when that channel's bit of `lim_wr_hi` or `lim_wr_lo` is set. A write takes effect for conversions in later cycles.
- R2: Flags and pin state change only on a cycle with `conv_done` high, a clear strobe, or a mode change. With none of these, they hold whatever `temp_result` does.
- R3: In window mode (mode bit 0), a conversion result strictly greater than the high limit sets `flag_hi` and activates the pin. A result strictly less than the low limit sets `flag_lo` and activates the pin. The comparison is a 16-bit two's-complement signed comparison with the two least significant bits of both operands treated as zero. An equal value does not trip.
- R4: In window mode, `cfg_rd` clears both flags and the pin of every channel.
- R5: In window mode, `gclr[i]` deactivates only channel i's pin and leaves its flags set.
- R6: In window mode, a new out-of-window result in the same cycle as a clear strobe wins: the corresponding flag and the pin end up set.
- R7: In hysteresis mode (mode bit 1), a result above the high limit makes the channel hot, which means `flag_hi` is 1 and the pin is active. The channel stays hot until a result strictly below the low limit. `flag_lo` always reads 0.
- R8: In hysteresis mode, `cfg_rd` and `gclr` have no effect on the flag or the pin.
- R9: `cfg_q` is an 8-bit configuration register, reset to `CFG_RST` (default 0) and written by `cfg_wr`. Bit 7 is channel 0 polarity, bit 6 is channel 0 mode, bit 3 is channel 1 polarity and bit 2 is channel 1 mode. The pin equals the active state XOR the inverted polarity bit. With polarity 0 the pin is active low, and with polarity 1 it is active high.
- R10: A channel with high limit 7FFCh and low limit 8000h never trips for any result. Its pin then simply reads the inverse of its polarity bit.
- R11: A configuration write that changes a channel's mode bit clears that channel's flags and pin state to inactive. This takes priority over a conversion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | Conversion-complete strobe |
| temp_result | input | 16 | Signed conversion result |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration register read strobe (clears window alerts) |
| gclr | input | 2 | Per-channel global alert-clear strobes |
| lim_wr_hi | input | 2 | Per-channel high-limit write enables |
| lim_wr_lo | input | 2 | Per-channel low-limit write enables |
| lim_wdata | input | 16 | Limit write data |
| cfg_q | output | 8 | Configuration register contents |
| alert_pin | output | 2 | Per-channel alert pin, polarity applied |
| flag_hi | output | 2 | Per-channel high flag |
| flag_lo | output | 2 | Per-channel low flag |

## Verification
The directed tests place results exactly on each limit, one step above or below it, and at the extreme codes. These show whether the comparison is strict and signed, and whether the low bits are masked. Clear strobes are applied alone, together with a tripping conversion, and in hysteresis mode. This separates the read path from the global-clear path, shows which one wins against a new event, and shows that hysteresis mode is immune to both. Giving the two channels different limits and modes checks that they stay independent. A long random run follows. Its results cluster around each channel's limits, and it mixes in limit and configuration writes. A bench model checks every output on every cycle of that run.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;

    typedef enum logic [1:0] {
        CH_A_QUIET  = 2'd0,
        CH_A_RAISED = 2'd1,
        CH_T_BELOW  = 2'd2,
        CH_T_ABOVE  = 2'd3
    } ch_state_e;

    localparam int CFG_W = 8;

    // channel 0 uses bits 7/6, channel 1 uses bits 3/2
    function automatic int pol_bit(input int ch);
        return 7 - 4 * ch;
    endfunction

    function automatic int mode_bit(input int ch);
        return 6 - 4 * ch;
    endfunction

endpackage

// File: rtl/alert_cfg_reg.sv
module alert_cfg_reg
    import temp_alert_pkg::*;
#(
    parameter int               NCH     = 2,
    parameter logic [CFG_W-1:0] CFG_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [NCH-1:0]   pol_q,
    output logic [NCH-1:0]   mode_chg,
    output logic [NCH-1:0]   mode_new
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (cfg_wr) begin
            cfg_q <= cfg_wdata;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_fields
        localparam int PB = pol_bit(ch);
        localparam int MB = mode_bit(ch);
        assign pol_q[ch]    = cfg_q[PB];
        assign mode_new[ch] = cfg_wdata[MB];
        assign mode_chg[ch] = cfg_wr && (cfg_wdata[MB] != cfg_q[MB]);
    end

endmodule

// File: rtl/alert_limit_regs.sv
module alert_limit_regs #(
    parameter int            NCH    = 2,
    parameter int            TW     = 16,
    parameter logic [TW-1:0] HI_RST = 16'h1900,
    parameter logic [TW-1:0] LO_RST = 16'h0A00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          lim_wr_hi,
    input  logic [NCH-1:0]          lim_wr_lo,
    input  logic [TW-1:0]           lim_wdata,
    output logic [NCH-1:0][TW-1:0]  hi_q,
    output logic [NCH-1:0][TW-1:0]  lo_q
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lim
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[ch] <= HI_RST;
                lo_q[ch] <= LO_RST;
            end else begin
                if (lim_wr_hi[ch]) hi_q[ch] <= lim_wdata;
                if (lim_wr_lo[ch]) lo_q[ch] <= lim_wdata;
            end
        end
    end

endmodule

// File: rtl/alert_channel.sv
module alert_channel
    import temp_alert_pkg::*;
#(
    parameter int TW       = 16,
    parameter int DROP     = 2,
    parameter bit MODE_RST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic          cfg_rd,
    input  logic          gclr,
    input  logic          mode_chg,
    input  logic          mode_new,
    output logic          active,
    output logic          flag_hi,
    output logic          flag_lo
);

    localparam logic [TW-1:0] RES_MASK = ~TW'((1 << DROP) - 1);
    localparam ch_state_e     ST_RST   = MODE_RST ? CH_T_BELOW : CH_A_QUIET;

    logic signed [TW-1:0] t_s, hi_s, lo_s;
    logic                 over_hi, under_lo, clr_any, in_alert;
    ch_state_e            st_q, st_n;
    logic                 fh_q, fh_n, fl_q, fl_n;

    assign t_s      = $signed(temp & RES_MASK);
    assign hi_s     = $signed(lim_hi & RES_MASK);
    assign lo_s     = $signed(lim_lo & RES_MASK);
    assign over_hi  = conv_done && (t_s > hi_s);
    assign under_lo = conv_done && (t_s < lo_s);
    assign clr_any  = cfg_rd || gclr;
    assign in_alert = (st_q == CH_A_QUIET) || (st_q == CH_A_RAISED);

    // next state
    always_comb begin
        st_n = st_q;
        if (mode_chg) begin
            st_n = mode_new ? CH_T_BELOW : CH_A_QUIET;
        end else begin
            unique case (st_q)
                CH_A_QUIET:  if (over_hi || under_lo) st_n = CH_A_RAISED;
                CH_A_RAISED: if (!(over_hi || under_lo) && clr_any) st_n = CH_A_QUIET;
                CH_T_BELOW:  if (over_hi) st_n = CH_T_ABOVE;
                CH_T_ABOVE:  if (under_lo) st_n = CH_T_BELOW;
                default:     st_n = ST_RST;
            endcase
        end
    end

    // window-mode flag latches
    always_comb begin
        fh_n = 1'b0;
        fl_n = 1'b0;
        if (!mode_chg && in_alert) begin
            fh_n = (fh_q && !cfg_rd) || over_hi;
            fl_n = (fl_q && !cfg_rd) || under_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fh_q <= 1'b0;
            fl_q <= 1'b0;
        end else begin
            fh_q <= fh_n;
            fl_q <= fl_n;
        end
    end

    assign active  = (st_q == CH_A_RAISED) || (st_q == CH_T_ABOVE);
    assign flag_hi = in_alert ? fh_q : (st_q == CH_T_ABOVE);
    assign flag_lo = in_alert ? fl_q : 1'b0;

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !clr_any && !mode_chg) |=> ($stable(st_q) && $stable(fh_q) && $stable(fl_q))); // R2

    AST_WINDOW_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_alert && over_hi && !mode_chg) |=> (fh_q && st_q == CH_A_RAISED)); // R3

    AST_GCLR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_A_RAISED && gclr && !cfg_rd && !conv_done && !mode_chg)
        |=> (st_q == CH_A_QUIET && $stable(fh_q) && $stable(fl_q))); // R5

    AST_HOT_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_T_ABOVE && !conv_done && !mode_chg) |=> (st_q == CH_T_ABOVE)); // R8

    AST_COOL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_T_BELOW && !over_hi && !mode_chg) |=> (st_q == CH_T_BELOW)); // R7

    AST_MODE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (!fh_q && !fl_q && !active)); // R11

endmodule

// File: rtl/alert_pin_drive.sv
module alert_pin_drive #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] active,
    input  logic [NCH-1:0] pol,
    output logic [NCH-1:0] pin
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pin
        assign pin[ch] = active[ch] ^ ~pol[ch];
    end

endmodule

// File: rtl/dual_temp_alert.sv
module dual_temp_alert
    import temp_alert_pkg::*;
#(
    parameter int               TW      = 16,
    parameter int               DROP    = 2,
    parameter logic [TW-1:0]    HI_RST  = 16'h1900,
    parameter logic [TW-1:0]    LO_RST  = 16'h0A00,
    parameter logic [CFG_W-1:0] CFG_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [TW-1:0]    temp_result,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_rd,
    input  logic [1:0]       gclr,
    input  logic [1:0]       lim_wr_hi,
    input  logic [1:0]       lim_wr_lo,
    input  logic [TW-1:0]    lim_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [1:0]       alert_pin,
    output logic [1:0]       flag_hi,
    output logic [1:0]       flag_lo
);

    localparam int NCH = 2;

    logic [NCH-1:0]         pol_q, mode_chg, mode_new, active;
    logic [NCH-1:0][TW-1:0] hi_q, lo_q;

    alert_cfg_reg #(.NCH(NCH), .CFG_RST(CFG_RST)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .pol_q(pol_q), .mode_chg(mode_chg), .mode_new(mode_new)
    );

    alert_limit_regs #(.NCH(NCH), .TW(TW), .HI_RST(HI_RST), .LO_RST(LO_RST)) i_lim (
        .clk(clk), .rst_n(rst_n), .lim_wr_hi(lim_wr_hi), .lim_wr_lo(lim_wr_lo),
        .lim_wdata(lim_wdata), .hi_q(hi_q), .lo_q(lo_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int MB = mode_bit(ch);
        alert_channel #(.TW(TW), .DROP(DROP), .MODE_RST(CFG_RST[MB])) i_chan (
            .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp_result),
            .lim_hi(hi_q[ch]), .lim_lo(lo_q[ch]), .cfg_rd(cfg_rd), .gclr(gclr[ch]),
            .mode_chg(mode_chg[ch]), .mode_new(mode_new[ch]),
            .active(active[ch]), .flag_hi(flag_hi[ch]), .flag_lo(flag_lo[ch])
        );
    end

    alert_pin_drive #(.NCH(NCH)) i_pin (
        .active(active), .pol(pol_q), .pin(alert_pin)
    );

endmodule

// File: tb/test_dual_temp_alert.sv
module test_dual_temp_alert;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] temp_result = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic [1:0]  gclr = '0;
    logic [1:0]  lim_wr_hi = '0;
    logic [1:0]  lim_wr_lo = '0;
    logic [15:0] lim_wdata = '0;
    logic [7:0]  cfg_q;
    logic [1:0]  alert_pin, flag_hi, flag_lo;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic        m_act[2], m_fh[2], m_fl[2];
    logic [15:0] m_hi[2], m_lo[2];
    logic [7:0]  m_cfg;

    always #5 clk = ~clk;

    dual_temp_alert i_dual_temp_alert (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_result(temp_result),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .gclr(gclr),
        .lim_wr_hi(lim_wr_hi), .lim_wr_lo(lim_wr_lo), .lim_wdata(lim_wdata),
        .cfg_q(cfg_q), .alert_pin(alert_pin), .flag_hi(flag_hi), .flag_lo(flag_lo)
    );

    function automatic logic gt(input logic [15:0] a, input logic [15:0] b);
        return $signed({a[15:2], 2'b00}) > $signed({b[15:2], 2'b00});
    endfunction

    function automatic logic [1:0] exp_pin();
        logic [1:0] p;
        for (int c = 0; c < 2; c++) p[c] = m_act[c] ^ ~m_cfg[7 - 4 * c];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_step(input logic conv, input logic [15:0] t, input logic crd,
                              input logic [1:0] gc, input logic cwr, input logic [7:0] cwd,
                              input logic [1:0] whi, input logic [1:0] wlo, input logic [15:0] wd);
        for (int c = 0; c < 2; c++) begin
            logic mb, nh, nl;
            mb = cwd[6 - 4 * c];
            nh = conv && gt(t, m_hi[c]);
            nl = conv && gt(m_lo[c], t);
            if (cwr && mb != m_cfg[6 - 4 * c]) begin
                m_act[c] = 1'b0; m_fh[c] = 1'b0; m_fl[c] = 1'b0;
            end else if (!m_cfg[6 - 4 * c]) begin
                m_fh[c]  = (m_fh[c] && !crd) || nh;
                m_fl[c]  = (m_fl[c] && !crd) || nl;
                m_act[c] = (m_act[c] && !crd && !gc[c]) || nh || nl;
            end else begin
                if (!m_act[c] && nh) m_act[c] = 1'b1;
                else if (m_act[c] && nl) m_act[c] = 1'b0;
                m_fh[c] = m_act[c];
                m_fl[c] = 1'b0;
            end
            if (whi[c]) m_hi[c] = wd;
            if (wlo[c]) m_lo[c] = wd;
        end
        if (cwr) m_cfg = cwd;
    endtask

    task automatic step(input logic conv, input logic [15:0] t, input logic crd,
                        input logic [1:0] gc, input logic cwr, input logic [7:0] cwd,
                        input logic [1:0] whi, input logic [1:0] wlo, input logic [15:0] wd);
        conv_done = conv; temp_result = t; cfg_rd = crd; gclr = gc;
        cfg_wr = cwr; cfg_wdata = cwd; lim_wr_hi = whi; lim_wr_lo = wlo; lim_wdata = wd;
        model_step(conv, t, crd, gc, cwr, cwd, whi, wlo, wd);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic conv(input logic [15:0] t);
        step(1'b1, t, 1'b0, 2'b00, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
    endtask

    task automatic rd();
        step(1'b0, 16'h0, 1'b1, 2'b00, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
    endtask

    task automatic wcfg(input logic [7:0] d);
        step(1'b0, 16'h0, 1'b0, 2'b00, 1'b1, d, 2'b00, 2'b00, 16'h0);
    endtask

    task automatic expect3(input string tag, input logic [1:0] p, input logic [1:0] fh, input logic [1:0] fl);
        chk({tag, " pin"}, {14'd0, alert_pin}, {14'd0, p});
        chk({tag, " flag_hi"}, {14'd0, flag_hi}, {14'd0, fh});
        chk({tag, " flag_lo"}, {14'd0, flag_lo}, {14'd0, fl});
    endtask

    function automatic logic [15:0] pick_temp(input int c);
        case ($urandom % 5)
            0: return m_hi[c] + 16'($urandom % 12) - 16'd6;
            1: return m_lo[c] + 16'($urandom % 12) - 16'd6;
            2: return 16'h7FFF;
            3: return 16'h8000;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < 2; c++) begin
            m_act[c] = 0; m_fh[c] = 0; m_fl[c] = 0; m_hi[c] = 16'h1900; m_lo[c] = 16'h0A00;
        end
        m_cfg = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state: window mode, active-low pins idle high
        chk("R9 reset cfg", {8'd0, cfg_q}, 16'h0000);
        expect3("R9 reset", 2'b11, 2'b00, 2'b00);

        conv(16'h1A00);
        expect3("R3 over high", 2'b00, 2'b11, 2'b00);
        step(1'b0, 16'h0, 1'b0, 2'b01, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
        expect3("R5 gclr ch0 only", 2'b01, 2'b11, 2'b00);
        rd();
        expect3("R4 cfg read clears", 2'b11, 2'b00, 2'b00);
        step(1'b1, 16'h0900, 1'b1, 2'b11, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
        expect3("R6 event beats clear", 2'b00, 2'b00, 2'b11);
        rd();
        conv(16'h1903);
        expect3("R3 equal high masked", 2'b11, 2'b00, 2'b00);
        conv(16'h0A00);
        expect3("R3 equal low", 2'b11, 2'b00, 2'b00);

        // R1 distinct limits per channel
        step(1'b0, 16'h0, 1'b0, 2'b00, 1'b0, m_cfg, 2'b10, 2'b00, 16'h2000);
        conv(16'h1A00);
        expect3("R1 independent limits", 2'b10, 2'b01, 2'b00);
        step(1'b0, 16'h0900, 1'b0, 2'b00, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
        expect3("R2 no conversion no change", 2'b10, 2'b01, 2'b00);
        rd();

        // therm mode both channels
        wcfg(8'h44);
        chk("R9 cfg write", {8'd0, cfg_q}, 16'h0044);
        conv(16'h2100);
        expect3("R7 hot", 2'b00, 2'b11, 2'b00);
        step(1'b0, 16'h0, 1'b1, 2'b11, 1'b0, m_cfg, 2'b00, 2'b00, 16'h0);
        expect3("R8 clears ignored", 2'b00, 2'b11, 2'b00);
        conv(16'h1000);
        expect3("R7 inside band holds", 2'b00, 2'b11, 2'b00);
        conv(16'h0A00);
        expect3("R7 equal low holds", 2'b00, 2'b11, 2'b00);
        conv(16'h0900);
        expect3("R7 below low cools", 2'b11, 2'b00, 2'b00);

        wcfg(8'h00);
        conv(16'h1A00);
        expect3("R3 ch0 raised", 2'b10, 2'b01, 2'b00);
        step(1'b1, 16'h1A00, 1'b0, 2'b00, 1'b1, 8'h40, 2'b00, 2'b00, 16'h0);
        expect3("R11 mode change clears", 2'b11, 2'b00, 2'b00);

        wcfg(8'h88);
        expect3("R9 active-high idle", 2'b00, 2'b00, 2'b00);
        conv(16'h1A00);
        expect3("R9 active-high trip", 2'b01, 2'b01, 2'b00);
        rd();

        step(1'b0, 16'h0, 1'b0, 2'b00, 1'b0, m_cfg, 2'b10, 2'b00, 16'h7FFC);
        step(1'b0, 16'h0, 1'b0, 2'b00, 1'b0, m_cfg, 2'b00, 2'b10, 16'h8000);
        conv(16'h7FFF);
        expect3("R10 disabled max", 2'b01, 2'b01, 2'b00);
        conv(16'h8000);
        expect3("R10 disabled min", 2'b01, 2'b01, 2'b01);
        wcfg(8'h80);
        expect3("R10 pin as output low pol", 2'b11, 2'b01, 2'b01);
        wcfg(8'h88);
        expect3("R10 pin as output high pol", 2'b01, 2'b01, 2'b01);

        // random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            logic        cv, crd, cwr;
            logic [1:0]  gc, whi, wlo;
            logic [7:0]  cwd;
            logic [15:0] t, wd;
            int          c;
            c   = int'($urandom % 2);
            cv  = ($urandom % 2) == 0;
            t   = pick_temp(c);
            crd = ($urandom % 8) == 0;
            gc  = {($urandom % 8) == 0, ($urandom % 8) == 0};
            cwr = ($urandom % 32) == 0;
            cwd = cwr ? 8'($urandom) : m_cfg;
            whi = (($urandom % 32) == 0) ? 2'(1 << c) : 2'b00;
            wlo = (($urandom % 32) == 0) ? 2'(1 << c) : 2'b00;
            wd  = whi != 0 ? m_lo[c] + 16'($urandom % 16'h0800) : m_hi[c] - 16'($urandom % 16'h0800);
            step(cv, t, crd, gc, cwr, cwd, whi, wlo, wd);
            chk("R1 random cfg", {8'd0, cfg_q}, {8'd0, m_cfg});
            chk("R9 random pin", {14'd0, alert_pin}, {14'd0, exp_pin()});
            chk("R3 random flag_hi", {14'd0, flag_hi}, {14'd0, m_fh[1], m_fh[0]});
            chk("R7 random flag_lo", {14'd0, flag_lo}, {14'd0, m_fl[1], m_fl[0]});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule